// File: doc/BRIEF.md
# Boot-Block Address Map and Program/Erase Guard

This block sits between the command decoder of a boot-block flash controller and its program/erase engine. Given the byte address of a requested program or erase, it works out which of the eleven erase blocks is addressed and returns that block's base address and size class, so the erase engine can walk the whole block. A strap input selects which end of the address space holds the layout. With the bottom-end layout, the small protected block sits at address zero. With the top-end layout, the same block sequence is mirrored and starts from the highest address.

The block also decides whether a job may run. Every job needs the program supply to be reported valid. The protected boot block also needs one of two unlock conditions: the write-protect input held high, or the high-voltage unlock flag seen on the reset pin. These conditions are checked when the start request arrives and again on every cycle until the engine reports completion. If a condition fails, the job is refused or aborted, and a status bit records the reason.

Top module: `bootmap_guard`

## Requirements
- R1: With `strap_top`=0, addresses decode in 8KB units from address 0. Units 0–1 give index 0 (16KB boot), unit 2 gives index 1, unit 3 gives index 2 (8KB parameter), units 4–15 give index 3 (96KB main), and each further group of 16 units gives indices 4 to 10 (128KB main).
- R2: With `strap_top`=1, the map is mirrored about the top of the space. Index 0 is the last 16KB. Indices 1 and 2 are the two 8KB blocks below it. Index 3 is the 96KB block below those. Indices 4 to 10 are 128KB blocks descending to address 0.
- R3: `blk_base` is the lowest byte address of the addressed block. `blk_size` encodes the block size as 0 = 16KB, 1 = 8KB, 2 = 96KB and 3 = 128KB. All three map outputs are loaded on every start request taken while idle.
- R4: An accepted start request raises `go` for exactly one cycle, in the cycle after the request, and raises `busy` in the same cycle.
- R5: A start on index 0 is refused when both `wp_hi` and `hv_unlock` are low. No `go` is produced, and `err_prog` (program) or `err_erase` (erase) is set.
- R6: Either `wp_hi`=1 or `hv_unlock`=1 on its own is enough to accept a job on the boot block.
- R7: For indices 1 to 10, `wp_hi` and `hv_unlock` have no effect, either at start or during the job.
- R8: A start with `vpp_ok`=0 is refused, with `err_vpp` set and no `go`.
- R9: If `vpp_ok` falls while `busy` is high, `busy` clears and `err_vpp` sets on the next edge.
- R10: If both unlock inputs are low while a boot-block job is busy, the job aborts on the next edge and sets the error bit matching its operation.
- R11: `job_done` while busy ends the job with no error bit set. A start request while busy is ignored and leaves the map outputs unchanged.
- R12: Every start request taken while idle first clears all three error bits, so they describe only the latest request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Confirm strobe for a program or erase |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_addr | input | ADDR_W | Byte address of the request |
| strap_top | input | 1 | 1 = protected block at the top of the space |
| wp_hi | input | 1 | Write-protect input high (unlocks boot block) |
| hv_unlock | input | 1 | High-voltage unlock seen on reset pin |
| vpp_ok | input | 1 | Program supply valid |
| job_done | input | 1 | Engine reports job completion |
| go | output | 1 | One-cycle start strobe to the engine |
| busy | output | 1 | Job in progress |
| blk_idx | output | 4 | Block index, 0 = boot block |
| blk_base | output | ADDR_W | Base byte address of the block |
| blk_size | output | 2 | Size class of the block |
| err_prog | output | 1 | Program refused or aborted by protection |
| err_erase | output | 1 | Erase refused or aborted by protection |
| err_vpp | output | 1 | Supply missing at start or lost during the job |

## Verification
The bench builds the block with the default `ADDR_W` of 20, which gives the full 1MB map. At that width every boundary named in R1 and R2 falls on a distinct 8KB unit, so the table of edge addresses can check both layouts down to single-unit blocks. Directed sequences then cover each unlock combination, supply loss and unlock loss in mid-job, and restarting from an error.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
   typedef enum logic [1:0] {
      SZ_BOOT16  = 2'd0,
      SZ_PARAM8  = 2'd1,
      SZ_MAIN96  = 2'd2,
      SZ_MAIN128 = 2'd3
   } blk_size_e;

   localparam int UNIT_BITS  = 7;   // 128 units of 1/128 of the space
   localparam int BOOT_UNITS = 2;
   localparam int M96_UNITS  = 12;
   localparam int M128_UNITS = 16;
endpackage

// File: rtl/bootmap_decode.sv
module bootmap_decode
   import bootmap_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              top,
   output logic [3:0]        idx,
   output logic [ADDR_W-1:0] base,
   output blk_size_e         size
);
   localparam int SHIFT = ADDR_W - UNIT_BITS;

   generate
      if (ADDR_W < UNIT_BITS + 1) begin : g_bad_width
         $error("bootmap_decode: ADDR_W must be at least 8");
      end
   endgenerate

   logic [UNIT_BITS-1:0] unit_raw, unit_m, lo_m, len_m, base_u;

   assign unit_raw = addr[ADDR_W-1 -: UNIT_BITS];
   assign unit_m   = top ? ~unit_raw : unit_raw;

   always_comb begin
      if (unit_m < UNIT_BITS'(BOOT_UNITS)) begin
         idx = 4'd0; lo_m = '0; len_m = UNIT_BITS'(BOOT_UNITS); size = SZ_BOOT16;
      end else if (unit_m == UNIT_BITS'(2)) begin
         idx = 4'd1; lo_m = UNIT_BITS'(2); len_m = UNIT_BITS'(1); size = SZ_PARAM8;
      end else if (unit_m == UNIT_BITS'(3)) begin
         idx = 4'd2; lo_m = UNIT_BITS'(3); len_m = UNIT_BITS'(1); size = SZ_PARAM8;
      end else if (unit_m < UNIT_BITS'(M128_UNITS)) begin
         idx = 4'd3; lo_m = UNIT_BITS'(4); len_m = UNIT_BITS'(M96_UNITS); size = SZ_MAIN96;
      end else begin
         idx   = 4'd3 + 4'(unit_m[UNIT_BITS-1:4]);
         lo_m  = {unit_m[UNIT_BITS-1:4], 4'b0000};
         len_m = UNIT_BITS'(M128_UNITS);
         size  = SZ_MAIN128;
      end
   end

   // mirrored layout: block's far edge in mirrored space becomes its base
   assign base_u = top ? ~(lo_m + len_m - UNIT_BITS'(1)) : lo_m;
   assign base   = ADDR_W'(base_u) << SHIFT;

   always_comb begin
      AST_IDX_RANGE: assert (idx <= 4'd10); // R1
   end
endmodule

// File: rtl/bootmap_ctl.sv
module bootmap_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_start,
   input  logic req_erase,
   input  logic is_boot,
   input  logic wp_hi,
   input  logic hv_unlock,
   input  logic vpp_ok,
   input  logic job_done,
   output logic take,
   output logic go,
   output logic busy,
   output logic err_prog,
   output logic err_erase,
   output logic err_vpp
);
   logic boot_q, erase_q, unlocked, start_locked;

   assign unlocked     = wp_hi | hv_unlock;
   assign take         = req_start & ~busy;
   assign start_locked = is_boot & ~unlocked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go <= 1'b0; busy <= 1'b0; boot_q <= 1'b0; erase_q <= 1'b0;
         err_prog <= 1'b0; err_erase <= 1'b0; err_vpp <= 1'b0;
      end else begin
         go <= 1'b0;
         if (take) begin
            err_vpp   <= ~vpp_ok;
            err_prog  <= start_locked & ~req_erase;
            err_erase <= start_locked & req_erase;
            if (vpp_ok && !start_locked) begin
               go      <= 1'b1;
               busy    <= 1'b1;
               boot_q  <= is_boot;
               erase_q <= req_erase;
            end
         end else if (busy) begin
            if (!vpp_ok) begin
               busy    <= 1'b0;
               err_vpp <= 1'b1;
            end else if (boot_q && !unlocked) begin
               busy <= 1'b0;
               if (erase_q) err_erase <= 1'b1;
               else         err_prog  <= 1'b1;
            end else if (job_done) begin
               busy <= 1'b0;
            end
         end
      end
   end

   AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !go); // R4
   AST_GO_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> busy); // R4
   AST_BOOT_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !busy && is_boot && !wp_hi && !hv_unlock) |=> (!go && (err_prog || err_erase))); // R5
   AST_NO_SUPPLY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !busy && !vpp_ok) |=> (!go && err_vpp)); // R8
   AST_SUPPLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !go && !vpp_ok) |=> (!busy && err_vpp)); // R9
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !go); // R11
endmodule

// File: rtl/bootmap_guard.sv
module bootmap_guard
   import bootmap_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_erase,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              strap_top,
   input  logic              wp_hi,
   input  logic              hv_unlock,
   input  logic              vpp_ok,
   input  logic              job_done,
   output logic              go,
   output logic              busy,
   output logic [3:0]        blk_idx,
   output logic [ADDR_W-1:0] blk_base,
   output logic [1:0]        blk_size,
   output logic              err_prog,
   output logic              err_erase,
   output logic              err_vpp
);
   logic [3:0]        d_idx;
   logic [ADDR_W-1:0] d_base;
   blk_size_e         d_size;
   logic              take;

   bootmap_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (req_addr),
      .top  (strap_top),
      .idx  (d_idx),
      .base (d_base),
      .size (d_size)
   );

   bootmap_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_start (req_start),
      .req_erase (req_erase),
      .is_boot   (d_idx == 4'd0),
      .wp_hi     (wp_hi),
      .hv_unlock (hv_unlock),
      .vpp_ok    (vpp_ok),
      .job_done  (job_done),
      .take      (take),
      .go        (go),
      .busy      (busy),
      .err_prog  (err_prog),
      .err_erase (err_erase),
      .err_vpp   (err_vpp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_idx  <= '0;
         blk_base <= '0;
         blk_size <= '0;
      end else if (take) begin
         blk_idx  <= d_idx;
         blk_base <= d_base;
         blk_size <= d_size;
      end
   end

   AST_MAP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(blk_base)); // R11
endmodule

// File: tb/bootmap_guard_test.sv
`timescale 1ns/1ps
module bootmap_guard_test;
   localparam int AW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 0, req_erase = 0, strap_top = 0, wp_hi = 0, hv_unlock = 0;
   logic vpp_ok = 0, job_done = 0;
   logic [AW-1:0] req_addr = '0;
   logic go, busy, err_prog, err_erase, err_vpp;
   logic [3:0] blk_idx;
   logic [AW-1:0] blk_base;
   logic [1:0] blk_size;

   int total = 0, bad = 0;

   always #2 clk = ~clk;

   bootmap_guard #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_erase(req_erase),
      .req_addr(req_addr), .strap_top(strap_top), .wp_hi(wp_hi),
      .hv_unlock(hv_unlock), .vpp_ok(vpp_ok), .job_done(job_done),
      .go(go), .busy(busy), .blk_idx(blk_idx), .blk_base(blk_base),
      .blk_size(blk_size), .err_prog(err_prog), .err_erase(err_erase),
      .err_vpp(err_vpp)
   );

   // {top, addr, idx, base, size}
   localparam int NV = 16;
   localparam logic [46:0] VEC [NV] = '{
      {1'b0, 20'h00000, 4'd0,  20'h00000, 2'd0},
      {1'b0, 20'h03FFF, 4'd0,  20'h00000, 2'd0},
      {1'b0, 20'h04000, 4'd1,  20'h04000, 2'd1},
      {1'b0, 20'h07FFF, 4'd2,  20'h06000, 2'd1},
      {1'b0, 20'h08000, 4'd3,  20'h08000, 2'd2},
      {1'b0, 20'h1FFFF, 4'd3,  20'h08000, 2'd2},
      {1'b0, 20'h20000, 4'd4,  20'h20000, 2'd3},
      {1'b0, 20'hFFFFF, 4'd10, 20'hE0000, 2'd3},
      {1'b1, 20'hFFFFF, 4'd0,  20'hFC000, 2'd0},
      {1'b1, 20'hFA123, 4'd1,  20'hFA000, 2'd1},
      {1'b1, 20'hF8000, 4'd2,  20'hF8000, 2'd1},
      {1'b1, 20'hE0000, 4'd3,  20'hE0000, 2'd2},
      {1'b1, 20'hF7FFF, 4'd3,  20'hE0000, 2'd2},
      {1'b1, 20'hDFFFF, 4'd4,  20'hC0000, 2'd3},
      {1'b1, 20'h00000, 4'd10, 20'h00000, 2'd3},
      {1'b1, 20'h1FFFF, 4'd10, 20'h00000, 2'd3}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic start(input bit erase, input logic [AW-1:0] a);
      req_erase = erase; req_addr = a; req_start = 1'b1;
      tick;
      req_start = 1'b0;
   endtask

   task automatic finish_job;
      job_done = 1'b1; tick; job_done = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk); tick; tick;
      // reset state
      chk(!go && !busy && !err_prog && !err_erase && !err_vpp && blk_idx == 0,
          "R4 reset state", {go, busy, err_prog, err_erase, err_vpp}, 0);
      rst_n = 1'b1; tick;

      // table walk: R1 R2 R3 R4 R11
      vpp_ok = 1'b1; wp_hi = 1'b1;
      for (int i = 0; i < NV; i++) begin
         strap_top = VEC[i][46];
         start(1'b0, VEC[i][45:26]);
         chk(blk_idx == VEC[i][25:22], VEC[i][46] ? "R2 index" : "R1 index",
             int'(blk_idx), int'(VEC[i][25:22]));
         chk(blk_base == VEC[i][21:2], "R3 base", int'(blk_base), int'(VEC[i][21:2]));
         chk(blk_size == VEC[i][1:0], "R3 size", int'(blk_size), int'(VEC[i][1:0]));
         chk(go && busy, "R4 go and busy", {go, busy}, 3);
         tick;
         chk(!go && busy, "R4 go one cycle", {go, busy}, 1);
         finish_job;
         chk(!busy && !err_prog && !err_erase && !err_vpp, "R11 done clean",
             {busy, err_prog, err_erase, err_vpp}, 0);
      end

      // R5: boot locked, program then erase
      strap_top = 1'b0; wp_hi = 1'b0; hv_unlock = 1'b0;
      start(1'b0, 20'h01000);
      chk(!go && !busy && err_prog && !err_erase, "R5 locked program",
          {go, busy, err_prog, err_erase}, 2);
      start(1'b1, 20'h01000);
      chk(!go && err_erase && !err_prog, "R5 locked erase R12 clears prog",
          {go, err_prog, err_erase}, 1);

      // R6: each unlock alone
      hv_unlock = 1'b1;
      start(1'b1, 20'h00000);
      chk(go && busy && !err_erase, "R6 hv unlock accepted R12 clear", {go, busy, err_erase}, 6);
      finish_job;
      hv_unlock = 1'b0; wp_hi = 1'b1;
      start(1'b0, 20'h02000);
      chk(go && busy, "R6 wp unlock accepted", {go, busy}, 3);
      finish_job;

      // R7: parameter/main with both unlocks low, including mid-job
      wp_hi = 1'b0;
      start(1'b1, 20'h05000);
      chk(go && busy && !err_erase, "R7 param ignores locks", {go, busy, err_erase}, 6);
      tick; tick;
      chk(busy && !err_erase && !err_prog, "R7 no abort mid-job", {busy, err_prog, err_erase}, 4);
      finish_job;

      // R8: supply missing at start
      vpp_ok = 1'b0;
      start(1'b0, 20'h40000);
      chk(!go && !busy && err_vpp, "R8 no supply refused", {go, busy, err_vpp}, 1);
      vpp_ok = 1'b1;

      // R9: supply drop mid-job
      start(1'b0, 20'h40000);
      chk(busy && !err_vpp, "R12 clears vpp error", {busy, err_vpp}, 2);
      vpp_ok = 1'b0; tick;
      chk(!busy && err_vpp, "R9 supply abort", {busy, err_vpp}, 1);
      vpp_ok = 1'b1;

      // R10: unlock drop during boot erase
      wp_hi = 1'b1;
      start(1'b1, 20'h00100);
      chk(busy && !err_vpp, "R10 boot erase running", {busy, err_vpp}, 2);
      tick;
      wp_hi = 1'b0; tick;
      chk(!busy && err_erase && !err_prog, "R10 unlock drop aborts erase",
          {busy, err_prog, err_erase}, 1);

      // R11: start while busy ignored
      wp_hi = 1'b1;
      start(1'b0, 20'h20000);
      chk(blk_idx == 4'd4, "R11 first job index", int'(blk_idx), 4);
      tick;
      start(1'b0, 20'h00000);
      chk(!go && busy && blk_idx == 4'd4 && blk_base == 20'h20000,
          "R11 start while busy ignored", int'(blk_base), 'h20000);
      finish_job;
      chk(!busy, "R11 job ends", busy, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule